// File: doc/BRIEF.md
# Single-Cell Charger Mode Sequencer

This block is the control sequencer of a single-cell lithium charger. It runs on a slow tick clock and reads comparator flags that have already been synchronized: supply lockout, input present, input overvoltage, an active-low charge enable, pack temperature, junction shutdown, thermal-loop activity, the battery level against the short, short-indicate, precharge and recharge thresholds, the low-current flag and the termination enable. It also reads the fault flag of an external safety timer. It drives the power-stage enable, a current-mode select, a power-good line, two status lines and the clear and hold controls of that timer.

The sequencer moves through lockout, sleep, a power-on wait, standby, a one-cycle begin step, charging, suspend and done. Each mode treats the timers differently: they are cleared in the wait, standby and begin modes and held in suspend and done. Termination and recharge detection both need their comparator flag to stay true for a parameterized dwell time. All open-drain outputs are shown as "pull low" bits, where 1 means the line is driven low and 0 means released.

Top module: `cell_charge_sequencer`

## Requirements
- R1: While `uvlo` is high, the block enters lockout on the next clock edge. In lockout `pg_on`, `stat` and `pwr_en` are all 0.
- R2: With `uvlo` low and `vin_ok` low, the block enters sleep from any mode on the next edge. In sleep `pg_on` is 0, `stat` is 2'b00, `pwr_en` is 0 and `tmr_clr` is 1.
- R3: When input becomes present, a power-on wait of POR_TICKS+1 cycles follows. During the wait `pg_on` is 0 and `stat` is 2'b00. After it, `pg_on` goes to 1.
- R4: While `en_n` is high the block sits in standby, with `tmr_clr` at 1 and `pwr_en` at 0. When `en_n` goes low, one begin cycle follows (`tmr_clr` at 1, `pwr_en` at 0), and then charging starts with `pwr_en` at 1.
- R5: If `pack_temp_ok` is low or `tj_hot` is high, the block suspends on the next edge: `pwr_en` is 0, `tmr_hold` is 1 and `stat` is 2'b00. Charging resumes on the edge after the condition clears.
- R6: `stat` is {line1, line2} with 1 meaning pulled low. Precharge is 2'b11, fast charge is 2'b10 and done is 2'b01. Every other condition shows 2'b00.
- R7: While charging, `cur_mode` is 0 (short recovery) when `bat_above_sc` is low, 1 (precharge) when only `bat_above_pre` is low, and 2 (fast) otherwise. When `bat_above_scind` is low, `stat` shows 2'b00.
- R8: When `ovp` is high, the block goes to standby on the next edge with `pwr_en` at 0. `pg_on` is 0 while `ovp` is high. Nothing is latched: once `ovp` clears, `pg_on` returns and, with `en_n` low, a new cycle starts.
- R9: Termination needs `i_below_term` high, `bat_below_rch` low, `term_en` high and the block charging, all without a break for DGL_TICKS+1 consecutive edges. The block then enters done on that last edge. A break of one cycle restarts the count.
- R10: While `tloop_act` is high, termination is never detected, however long the current stays low.
- R11: The done state is cleared by `en_n` going high, by overvoltage, by a new cycle, or by `term_en` going low. While `term_en` is low, `stat` never shows 2'b01.
- R12: In done, when `bat_below_rch` stays high for DGL_TICKS+1 edges, a new cycle starts: one begin cycle with `tmr_clr` at 1, then charging.
- R13: While charging, a high `tmr_fault` forces `pwr_en` to 0 and `stat` to 2'b00 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow tick clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| uvlo | input | 1 | Supply below lockout level |
| vin_ok | input | 1 | Input power detected |
| ovp | input | 1 | Input overvoltage |
| en_n | input | 1 | Charge enable, active low |
| pack_temp_ok | input | 1 | Pack temperature inside window |
| tj_hot | input | 1 | Junction shutdown active |
| tloop_act | input | 1 | Thermal regulation loop active |
| bat_above_pre | input | 1 | Battery above precharge threshold |
| bat_above_sc | input | 1 | Battery above lower short threshold |
| bat_above_scind | input | 1 | Battery above short-indicate level |
| bat_below_rch | input | 1 | Battery below recharge threshold |
| i_below_term | input | 1 | Charge current below termination level |
| term_en | input | 1 | Termination detection enabled |
| tmr_fault | input | 1 | Safety timer expired (latched externally) |
| pwr_en | output | 1 | Power stage on |
| cur_mode | output | 2 | 0 short recovery, 1 precharge, 2 fast |
| pg_on | output | 1 | Power-good line pulled low |
| stat | output | 2 | Status lines {1,2}, 1 = pulled low |
| tmr_clr | output | 1 | Clear the safety timers |
| tmr_hold | output | 1 | Freeze the safety timers |

## Verification
The bench holds the low-current flag for exactly the dwell length and checks that done appears one edge later and not earlier. A counter that was off by one would show done a cycle early or late. A one-cycle break in the middle of the dwell must restart the count; a counter that only paused instead of clearing would terminate early. Termination is also attempted with the thermal loop active and with termination disabled, where a missing gate would show 2'b01. The bench drops the enable from done, applies overvoltage and removes input during charging, and checks that each one clears done, power-good and the power stage. A latched overvoltage or a done state that survived would leave the status wrong on the next cycle.

// File: rtl/chg_seq_pkg.sv
package chg_seq_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_SLEEP = 3'd1,
        ST_POR   = 3'd2,
        ST_STBY  = 3'd3,
        ST_BEGIN = 3'd4,
        ST_CHG   = 3'd5,
        ST_SUSP  = 3'd6,
        ST_DONE  = 3'd7
    } seq_st_e;

    localparam logic [1:0] MODE_SHORT = 2'd0;
    localparam logic [1:0] MODE_PRE   = 2'd1;
    localparam logic [1:0] MODE_FAST  = 2'd2;

    localparam logic [1:0] STAT_PRE  = 2'b11;
    localparam logic [1:0] STAT_FAST = 2'b10;
    localparam logic [1:0] STAT_DONE = 2'b01;
    localparam logic [1:0] STAT_OFF  = 2'b00;

    localparam int unsigned NUM_DWELL = 3;

    typedef struct packed {
        seq_st_e st;
    } seq_reg_t;

endpackage

// File: rtl/chg_dwell_cnt.sv
module chg_dwell_cnt #(
    parameter int unsigned TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    output logic hit
);
    localparam int unsigned CW = $clog2(TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TICKS);

    logic [CW-1:0] cnt_d, cnt_q;

    // consecutive-cycle counter, cleared by any break in cond
    always_comb begin
        if (!cond) begin
            cnt_d = '0;
        end else if (cnt_q != LIMIT) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit = cond && (cnt_q == LIMIT);

endmodule

// File: rtl/chg_out_dec.sv
module chg_out_dec
    import chg_seq_pkg::*;
(
    input  seq_st_e    st,
    input  logic       ovp,
    input  logic       tmr_fault,
    input  logic       term_en,
    input  logic       bat_above_pre,
    input  logic       bat_above_sc,
    input  logic       bat_above_scind,
    output logic       pwr_en,
    output logic [1:0] cur_mode,
    output logic       pg_on,
    output logic [1:0] stat,
    output logic       tmr_clr,
    output logic       tmr_hold
);
    logic powered;
    logic charging;

    always_comb begin
        powered  = (st == ST_STBY) || (st == ST_BEGIN) || (st == ST_CHG) ||
                   (st == ST_SUSP) || (st == ST_DONE);
        charging = (st == ST_CHG) && !tmr_fault;

        pg_on    = powered && !ovp;
        tmr_clr  = (st == ST_OFF) || (st == ST_SLEEP) || (st == ST_POR) ||
                   (st == ST_STBY) || (st == ST_BEGIN);
        tmr_hold = (st == ST_SUSP) || (st == ST_DONE);
        pwr_en   = charging;

        if (!bat_above_sc) begin
            cur_mode = MODE_SHORT;
        end else if (!bat_above_pre) begin
            cur_mode = MODE_PRE;
        end else begin
            cur_mode = MODE_FAST;
        end

        stat = STAT_OFF;
        if (charging && bat_above_scind) begin
            stat = bat_above_pre ? STAT_FAST : STAT_PRE;
        end else if ((st == ST_DONE) && term_en) begin
            stat = STAT_DONE;
        end
    end

endmodule

// File: rtl/cell_charge_sequencer.sv
module cell_charge_sequencer
    import chg_seq_pkg::*;
#(
    parameter int unsigned POR_TICKS = 8,
    parameter int unsigned DGL_TICKS = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       uvlo,
    input  logic       vin_ok,
    input  logic       ovp,
    input  logic       en_n,
    input  logic       pack_temp_ok,
    input  logic       tj_hot,
    input  logic       tloop_act,
    input  logic       bat_above_pre,
    input  logic       bat_above_sc,
    input  logic       bat_above_scind,
    input  logic       bat_below_rch,
    input  logic       i_below_term,
    input  logic       term_en,
    input  logic       tmr_fault,
    output logic       pwr_en,
    output logic [1:0] cur_mode,
    output logic       pg_on,
    output logic [1:0] stat,
    output logic       tmr_clr,
    output logic       tmr_hold
);
    localparam int unsigned DW_POR  = 0;
    localparam int unsigned DW_TERM = 1;
    localparam int unsigned DW_RCH  = 2;

    seq_reg_t cur_q, nxt_d;
    logic     temp_bad;
    logic [NUM_DWELL-1:0] dw_cond;
    logic [NUM_DWELL-1:0] dw_hit;

    assign temp_bad = !pack_temp_ok || tj_hot;

    always_comb begin
        dw_cond          = '0;
        dw_cond[DW_POR]  = (cur_q.st == ST_POR);
        dw_cond[DW_TERM] = (cur_q.st == ST_CHG) && !temp_bad && term_en &&
                           !tloop_act && i_below_term && !bat_below_rch;
        dw_cond[DW_RCH]  = (cur_q.st == ST_DONE) && bat_below_rch;
    end

    for (genvar g = 0; g < NUM_DWELL; g++) begin : g_dwell
        localparam int unsigned T = (g == DW_POR) ? POR_TICKS : DGL_TICKS;
        chg_dwell_cnt #(.TICKS(T)) u_dw (
            .clk   (clk),
            .rst_n (rst_n),
            .cond  (dw_cond[g]),
            .hit   (dw_hit[g])
        );
    end

    always_comb begin
        nxt_d = cur_q;
        if (uvlo) begin
            nxt_d.st = ST_OFF;
        end else if (!vin_ok) begin
            nxt_d.st = ST_SLEEP;
        end else begin
            case (cur_q.st)
                ST_OFF, ST_SLEEP: nxt_d.st = ST_POR;
                ST_POR: begin
                    if (dw_hit[DW_POR]) begin
                        nxt_d.st = (ovp || en_n) ? ST_STBY : ST_BEGIN;
                    end
                end
                default: begin
                    if (ovp || en_n) begin
                        nxt_d.st = ST_STBY;
                    end else begin
                        case (cur_q.st)
                            ST_STBY:  nxt_d.st = ST_BEGIN;
                            ST_BEGIN: nxt_d.st = temp_bad ? ST_SUSP : ST_CHG;
                            ST_CHG: begin
                                if (temp_bad) begin
                                    nxt_d.st = ST_SUSP;
                                end else if (dw_hit[DW_TERM]) begin
                                    nxt_d.st = ST_DONE;
                                end
                            end
                            ST_SUSP: begin
                                if (!temp_bad) begin
                                    nxt_d.st = ST_CHG;
                                end
                            end
                            ST_DONE: begin
                                if (!term_en) begin
                                    nxt_d.st = ST_CHG;
                                end else if (dw_hit[DW_RCH]) begin
                                    nxt_d.st = ST_BEGIN;
                                end
                            end
                            default: nxt_d.st = ST_OFF;
                        endcase
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.st <= ST_OFF;
        end else begin
            cur_q <= nxt_d;
        end
    end

    chg_out_dec u_dec (
        .st              (cur_q.st),
        .ovp             (ovp),
        .tmr_fault       (tmr_fault),
        .term_en         (term_en),
        .bat_above_pre   (bat_above_pre),
        .bat_above_sc    (bat_above_sc),
        .bat_above_scind (bat_above_scind),
        .pwr_en          (pwr_en),
        .cur_mode        (cur_mode),
        .pg_on           (pg_on),
        .stat            (stat),
        .tmr_clr         (tmr_clr),
        .tmr_hold        (tmr_hold)
    );

endmodule

// File: rtl/chg_seq_chk.sv
module chg_seq_chk #(
    parameter int unsigned POR_TICKS = 8,
    parameter int unsigned DGL_TICKS = 25
) (
    input logic       clk,
    input logic       rst_n,
    input logic       uvlo,
    input logic       vin_ok,
    input logic       ovp,
    input logic       pack_temp_ok,
    input logic       tj_hot,
    input logic       i_below_term,
    input logic       pwr_en,
    input logic [1:0] cur_mode,
    input logic       pg_on,
    input logic [1:0] stat
);
    localparam int unsigned PW = $clog2(POR_TICKS + 3);
    localparam int unsigned LW = $clog2(DGL_TICKS + 2);
    localparam logic [PW-1:0] PMAX = PW'(POR_TICKS + 2);
    localparam logic [LW-1:0] LMAX = LW'(DGL_TICKS + 1);

    logic [PW-1:0] pres_cnt;
    logic [LW-1:0] lowi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pres_cnt <= '0;
            lowi_cnt <= '0;
        end else begin
            if (!(vin_ok && !uvlo)) pres_cnt <= '0;
            else if (pres_cnt != PMAX) pres_cnt <= pres_cnt + 1'b1;
            if (!i_below_term) lowi_cnt <= '0;
            else if (lowi_cnt != LMAX) lowi_cnt <= lowi_cnt + 1'b1;
        end
    end

    // R1
    pdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uvlo |=> (!pg_on && stat == 2'b00 && !pwr_en));

    // R2
    sleep_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!vin_ok && !uvlo) |=> (!pg_on && !pwr_en));

    // R3
    por_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pg_on |-> (pres_cnt > PW'(POR_TICKS)));

    // R5
    suspend_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pack_temp_ok || tj_hot) |=> !pwr_en);

    // R6
    pre_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == 2'b11) |-> (cur_mode == 2'd1 && pwr_en));

    // R8
    ovp_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovp |=> !pwr_en);

    // R9
    term_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == 2'b01 && $past(stat) != 2'b01) |-> (lowi_cnt >= LW'(DGL_TICKS)));

endmodule

bind cell_charge_sequencer chg_seq_chk #(
    .POR_TICKS (POR_TICKS),
    .DGL_TICKS (DGL_TICKS)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .uvlo         (uvlo),
    .vin_ok       (vin_ok),
    .ovp          (ovp),
    .pack_temp_ok (pack_temp_ok),
    .tj_hot       (tj_hot),
    .i_below_term (i_below_term),
    .pwr_en       (pwr_en),
    .cur_mode     (cur_mode),
    .pg_on        (pg_on),
    .stat         (stat)
);

// File: tb/sim_cell_charge_sequencer.sv
module sim_cell_charge_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int POR_T = 8;
    localparam int DGL_T = 25;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic uvlo = 1'b1, vin_ok = 1'b0, ovp = 1'b0, en_n = 1'b1;
    logic pack_temp_ok = 1'b1, tj_hot = 1'b0, tloop_act = 1'b0;
    logic bat_above_pre = 1'b1, bat_above_sc = 1'b1, bat_above_scind = 1'b1;
    logic bat_below_rch = 1'b1, i_below_term = 1'b0, term_en = 1'b1, tmr_fault = 1'b0;
    logic pwr_en, pg_on, tmr_clr, tmr_hold;
    logic [1:0] cur_mode, stat;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cell_charge_sequencer #(.POR_TICKS(POR_T), .DGL_TICKS(DGL_T)) u0 (
        .clk(clk), .rst_n(rst_n), .uvlo(uvlo), .vin_ok(vin_ok), .ovp(ovp),
        .en_n(en_n), .pack_temp_ok(pack_temp_ok), .tj_hot(tj_hot),
        .tloop_act(tloop_act), .bat_above_pre(bat_above_pre),
        .bat_above_sc(bat_above_sc), .bat_above_scind(bat_above_scind),
        .bat_below_rch(bat_below_rch), .i_below_term(i_below_term),
        .term_en(term_en), .tmr_fault(tmr_fault), .pwr_en(pwr_en),
        .cur_mode(cur_mode), .pg_on(pg_on), .stat(stat),
        .tmr_clr(tmr_clr), .tmr_hold(tmr_hold)
    );

    task automatic check(input string rq, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", rq, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cyc(); cyc();
        rst_n = 1'b1;
        cyc();
        check("R1 lockout pg", pg_on, 0);
        check("R1 lockout stat", stat, 0);
        check("R1 lockout pwr", pwr_en, 0);
    endtask

    task automatic t_powerup();
        uvlo = 1'b0; vin_ok = 1'b1; en_n = 1'b1;
        cyc();
        check("R3 wait pg", pg_on, 0);
        for (int i = 0; i < POR_T; i++) begin
            cyc();
            check("R3 wait pg", pg_on, 0);
            check("R3 wait stat", stat, 0);
        end
        cyc();
        check("R3 pg after wait", pg_on, 1);
        check("R4 standby clr", tmr_clr, 1);
        check("R4 standby pwr", pwr_en, 0);
    endtask

    task automatic t_start();
        en_n = 1'b0;
        cyc();
        check("R4 begin clr", tmr_clr, 1);
        check("R4 begin pwr", pwr_en, 0);
        cyc();
        check("R4 charging pwr", pwr_en, 1);
        check("R6 fast code", stat, 2);
        check("R7 fast mode", cur_mode, 2);
    endtask

    task automatic t_modes();
        bat_above_pre = 1'b0; #1;
        check("R6 pre code", stat, 3);
        check("R7 pre mode", cur_mode, 1);
        bat_above_scind = 1'b0; #1;
        check("R7 short indicate", stat, 0);
        check("R7 still pre mode", cur_mode, 1);
        bat_above_sc = 1'b0; #1;
        check("R7 short mode", cur_mode, 0);
        bat_above_pre = 1'b1; bat_above_sc = 1'b1; bat_above_scind = 1'b1; #1;
        check("R7 back fast", cur_mode, 2);
    endtask

    task automatic t_suspend();
        pack_temp_ok = 1'b0;
        cyc();
        check("R5 temp pwr", pwr_en, 0);
        check("R5 temp hold", tmr_hold, 1);
        check("R5 temp stat", stat, 0);
        pack_temp_ok = 1'b1;
        cyc();
        check("R5 resume", pwr_en, 1);
        tj_hot = 1'b1;
        cyc();
        check("R5 tj pwr", pwr_en, 0);
        tj_hot = 1'b0;
        cyc();
        check("R5 tj resume", stat, 2);
    endtask

    task automatic t_fault();
        tmr_fault = 1'b1; #1;
        check("R13 fault pwr", pwr_en, 0);
        check("R13 fault stat", stat, 0);
        tmr_fault = 1'b0; #1;
        check("R13 fault cleared", pwr_en, 1);
    endtask

    task automatic t_glitch();
        bat_below_rch = 1'b0; i_below_term = 1'b1;
        for (int i = 0; i < DGL_T; i++) cyc();
        i_below_term = 1'b0;
        cyc();
        i_below_term = 1'b1;
        for (int i = 0; i < DGL_T; i++) cyc();
        check("R9 break restarts", stat, 2);
        i_below_term = 1'b0;
        cyc();
    endtask

    task automatic t_tloop();
        tloop_act = 1'b1; bat_below_rch = 1'b0; i_below_term = 1'b1;
        for (int i = 0; i < 2*DGL_T + 4; i++) cyc();
        check("R10 no term under loop", stat, 2);
        tloop_act = 1'b0; i_below_term = 1'b0;
        cyc();
    endtask

    task automatic t_term();
        bat_below_rch = 1'b0; i_below_term = 1'b1;
        for (int i = 0; i < DGL_T; i++) cyc();
        check("R9 not yet done", stat, 2);
        cyc();
        check("R9 done code", stat, 1);
        check("R9 done pwr", pwr_en, 0);
    endtask

    task automatic t_recharge();
        i_below_term = 1'b0; bat_below_rch = 1'b1;
        for (int i = 0; i < DGL_T; i++) cyc();
        check("R12 still done", stat, 1);
        cyc();
        check("R12 begin clr", tmr_clr, 1);
        check("R12 begin stat", stat, 0);
        cyc();
        check("R12 charging", stat, 2);
    endtask

    task automatic t_term_disable();
        term_en = 1'b0; #1;
        check("R11 done hidden", stat, 0);
        cyc();
        check("R11 back charging", stat, 2);
        for (int i = 0; i < 2*DGL_T + 4; i++) cyc();
        check("R11 no done when disabled", stat, 2);
        term_en = 1'b1; i_below_term = 1'b0;
        cyc();
    endtask

    task automatic t_en_clear();
        en_n = 1'b1;
        cyc();
        check("R11 enable high standby", stat, 0);
        check("R4 enable high pwr", pwr_en, 0);
        i_below_term = 1'b0; en_n = 1'b0;
        cyc(); cyc();
        check("R11 done cleared", stat, 2);
    endtask

    task automatic t_ovp();
        ovp = 1'b1;
        cyc();
        check("R8 ovp pwr", pwr_en, 0);
        check("R8 ovp pg", pg_on, 0);
        check("R8 ovp stat", stat, 0);
        ovp = 1'b0; #1;
        check("R8 pg returns", pg_on, 1);
        cyc(); cyc();
        check("R8 restart", pwr_en, 1);
    endtask

    task automatic t_sleep();
        vin_ok = 1'b0;
        cyc();
        check("R2 sleep pg", pg_on, 0);
        check("R2 sleep pwr", pwr_en, 0);
        check("R2 sleep stat", stat, 0);
        check("R2 sleep clr", tmr_clr, 1);
        vin_ok = 1'b1;
        cyc();
        check("R3 wait after sleep", pg_on, 0);
    endtask

    task automatic t_pdown();
        uvlo = 1'b1;
        cyc();
        check("R1 lockout pg", pg_on, 0);
        check("R1 lockout pwr", pwr_en, 0);
        check("R1 lockout stat", stat, 0);
    endtask

    initial begin
        t_reset();
        t_powerup();
        t_start();
        t_modes();
        t_suspend();
        t_fault();
        t_glitch();
        t_tloop();
        t_term();
        t_recharge();
        t_term();
        t_term_disable();
        t_term();
        t_en_clear();
        t_ovp();
        t_sleep();
        t_pdown();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule